// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It does this by reading a two-level translation structure from memory. A directory base input holds the physical address of the current directory, and software changes it when the address space switches. For each request the walker does the following:

- It reads one directory word and, unless that word maps a 4 MB region directly, one table word.
- It checks each word for presence and permission against the kind of access.
- It returns either a translation with the effective permissions, or a fault record.

When the access succeeds and the leaf entry still lacks its accessed bit, or lacks its dirty bit on a write, the walker writes the entry back with those bits set. The read and the write-back together form a read-modify-write. The walker talks to memory over a valid/ready request channel, and the read data comes back on a separate valid strobe after any number of cycles. It handles one translation at a time and shows a busy flag while it works.

Entry layout, shared by both levels:

| Bits | Meaning |
|------|---------|
| 31:12 | frame number |
| 7 | large-page mapping, directory level only |
| 6 | dirty |
| 5 | accessed |
| 2 | user may access |
| 1 | writable |
| 0 | present |

Top module: `pgwalk_top`

## Requirements
- R1: The virtual address is split into three fields: a directory index in bits 31:22, a table index in bits 21:12 and a byte offset in bits 11:0. The first read of a walk goes to `dir_base + 4*directory index`.
- R2: For a present directory entry with bit 7 clear, the second read goes to `{entry[31:12], 12'h000} + 4*table index`.
- R3: On a successful 4 KB walk:
  - `rsp_pa = {table_entry[31:12], va[11:0]}` and `rsp_large = 0`.
  - `rsp_perm[0]` is the AND of the writable bits (bit 1) of both entries.
  - `rsp_perm[1]` is the AND of their user bits (bit 2).
- R4: A present directory entry with bit 7 set maps a 4 MB page directly, and no table read takes place. The result is `rsp_pa = {entry[31:22], va[21:0]}`, `rsp_large = 1`, and `rsp_perm` comes from that entry's bits 2 and 1.
- R5: An entry with bit 0 clear ends the walk with a fault. The fault record is:
  - `rsp_fault = 1`
  - `rsp_flt_type = 1` (not present)
  - `rsp_flt_level` = 0 for the directory or 1 for the table
  - `rsp_flt_va` = the request address
- R6: When `req_user = 1` and a checked entry has bit 2 clear, the walk faults with type 3 at that entry's level. When `req_user = 0`, bit 2 is ignored.
- R7: When `req_write = 1` and a checked entry has bit 1 clear, the walk faults with type 2 at that entry's level. Within one entry the order of precedence is not-present, then user, then write.
- R8: On success the leaf entry (the table entry, or a large directory entry) is written back to its own address once. The written value has bit 5 set, and also bit 6 set when the access is a write.
- R9: No memory write is issued when the leaf entry already holds the bits R8 would set, or when the walk faults.
- R10:
  - After reset, `busy`, `rsp_valid` and `mem_req_valid` are 0.
  - `busy` stays 1 from the cycle after acceptance until the cycle in which `rsp_valid` pulses for exactly one cycle.
  - `req_valid` is ignored while `busy` is 1.
- R11: A memory request stays asserted with its address, data and direction held until `mem_req_ready` is seen. Read data is accepted after any delay.
- R12: Timing, with memory always ready and read latency L counted from the request handshake edge to the edge that samples `mem_rsp_valid`. `rsp_valid` is seen after the following edge, counted from the acceptance edge:
  - directory fault: edge 1+L
  - table-level result without write-back: edge 2+2L
  - 4 KB success with write-back: edge 3+2L
  - large page with write-back: edge 2+L

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Physical address of the current directory |
| req_valid | input | 1 | Translation request, taken when busy is low |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| busy | output | 1 | A walk is in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Result is a fault |
| rsp_pa | output | 32 | Translated physical address |
| rsp_perm | output | 2 | Effective {user, writable} |
| rsp_large | output | 1 | Translation came from a 4 MB mapping |
| rsp_flt_level | output | 1 | Faulting level: 0 directory, 1 table |
| rsp_flt_type | output | 2 | 1 not present, 2 write, 3 user |
| rsp_flt_va | output | 32 | Virtual address that faulted |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Word address in bytes |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
Each walk's result is due a fixed number of edges after its acceptance edge. That number follows from the read latency the bench memory uses and from whether a write-back is needed:

- 1+L for a directory fault
- 2+L for a large page with write-back
- 2+2L for a table-level result without write-back
- 3+2L for a 4 KB page with write-back

The bench records the cycle count at acceptance and samples `rsp_valid` on falling edges. It compares the number of edges counted against that formula. The bench memory logs every read address and every write, so the entry addresses, the count of write-backs and the merged entry values are checked directly. The latency check is skipped only in the scenario that stalls `mem_req_ready`.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 32;
  localparam int ENT_W    = 32;
  localparam int IDX_W    = 10;
  localparam int OFF_W    = 12;
  localparam int LOFF_W   = OFF_W + IDX_W;
  localparam int ESZ_LG   = 2;
  localparam int PAD_W    = PA_W - IDX_W - ESZ_LG;

  localparam int B_P = 0;
  localparam int B_W = 1;
  localparam int B_U = 2;
  localparam int B_A = 5;
  localparam int B_D = 6;
  localparam int B_L = 7;

  localparam logic [ENT_W-1:0] AD_MASK = (ENT_W'(1) << B_A) | (ENT_W'(1) << B_D);

  typedef enum logic [1:0] {
    FT_NONE = 2'd0,
    FT_NP   = 2'd1,
    FT_WR   = 2'd2,
    FT_USR  = 2'd3
  } flt_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DIR  = 2'd1,
    S_TBL  = 2'd2,
    S_WB   = 2'd3
  } wstate_t;

  function automatic logic [PA_W-1:0] dir_ent_addr(input logic [PA_W-1:0] base,
                                                   input logic [VA_W-1:0] va);
    return base + {{PAD_W{1'b0}}, va[VA_W-1 -: IDX_W], {ESZ_LG{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] tbl_ent_addr(input logic [ENT_W-1:0] pde,
                                                   input logic [VA_W-1:0] va);
    return {pde[ENT_W-1:OFF_W], {OFF_W{1'b0}}}
         + {{PAD_W{1'b0}}, va[LOFF_W-1 -: IDX_W], {ESZ_LG{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] small_pa(input logic [ENT_W-1:0] pte,
                                               input logic [VA_W-1:0] va);
    return {pte[ENT_W-1:OFF_W], va[OFF_W-1:0]};
  endfunction

  function automatic logic [PA_W-1:0] large_pa(input logic [ENT_W-1:0] pde,
                                               input logic [VA_W-1:0] va);
    return {pde[ENT_W-1:LOFF_W], va[LOFF_W-1:0]};
  endfunction

  function automatic logic [ENT_W-1:0] mark_used(input logic [ENT_W-1:0] ent,
                                                 input logic wr);
    logic [ENT_W-1:0] r;
    r = ent;
    r[B_A] = 1'b1;
    if (wr) r[B_D] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/pgwalk_check.sv
module pgwalk_check
  import pgwalk_pkg::*;
(
  input  logic [ENT_W-1:0] ent,
  input  logic             at_dir,
  input  logic             acc_wr,
  input  logic             acc_usr,
  output logic             flt,
  output flt_t             ftype,
  output logic             leaf,
  output logic [ENT_W-1:0] upd_ent,
  output logic             need_wb
);
  // Precedence inside one entry: presence, then privilege, then write permission.
  always_comb begin
    ftype = FT_NONE;
    if (!ent[B_P])                  ftype = FT_NP;
    else if (acc_usr && !ent[B_U])  ftype = FT_USR;
    else if (acc_wr && !ent[B_W])   ftype = FT_WR;
  end

  assign flt     = (ftype != FT_NONE);
  assign leaf    = !at_dir || ent[B_L];
  assign upd_ent = mark_used(ent, acc_wr);
  assign need_wb = leaf && !flt && (upd_ent != ent);
endmodule

// File: rtl/pgwalk_memreq.sv
module pgwalk_memreq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic          issue_write,
  input  logic [DW-1:0] issue_wdata,
  input  logic          mem_req_ready,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  output logic          done
);
  logic          vld_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (issue) begin
      vld_q  <= 1'b1;
      wr_q   <= issue_write;
      addr_q <= issue_addr;
      data_q <= issue_wdata;
    end else if (done) begin
      vld_q  <= 1'b0;
    end
  end

  assign done          = vld_q && mem_req_ready;
  assign mem_req_valid = vld_q;
  assign mem_req_write = wr_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = data_q;

  // R11: a new request never overlaps one that is still waiting for ready
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !mem_req_valid);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  dir_base,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_perm,
  output logic             rsp_large,
  output logic             rsp_flt_level,
  output logic [1:0]       rsp_flt_type,
  output logic [VA_W-1:0]  rsp_flt_va,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [ENT_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_rdata
);
  wstate_t          state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, usr_q;
  logic [1:0]       dperm_q;
  logic [PA_W-1:0]  ent_addr_q;
  logic [ENT_W-1:0] wb_old_q;

  logic             chk_flt, chk_leaf, chk_wb;
  flt_t             chk_type;
  logic [ENT_W-1:0] chk_upd;

  logic             issue, issue_wr, mem_done;
  logic [PA_W-1:0]  issue_addr;

  logic             accept, res_ld, fire;
  logic             ld_fault, ld_large, ld_level;
  flt_t             ld_type;
  logic [PA_W-1:0]  ld_pa;
  logic [1:0]       ld_perm;

  logic             fault_q, large_q, level_q, rsp_valid_q;
  flt_t             ftype_q;
  logic [PA_W-1:0]  pa_q;
  logic [1:0]       perm_q;
  logic [VA_W-1:0]  fva_q;

  pgwalk_check u_check (
    .ent     (mem_rsp_rdata),
    .at_dir  (state_q == S_DIR),
    .acc_wr  (wr_q),
    .acc_usr (usr_q),
    .flt     (chk_flt),
    .ftype   (chk_type),
    .leaf    (chk_leaf),
    .upd_ent (chk_upd),
    .need_wb (chk_wb)
  );

  pgwalk_memreq #(.AW(PA_W), .DW(ENT_W)) u_memreq (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue         (issue),
    .issue_addr    (issue_addr),
    .issue_write   (issue_wr),
    .issue_wdata   (chk_upd),
    .mem_req_ready (mem_req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .done          (mem_done)
  );

  assign accept = req_valid && (state_q == S_IDLE);

  always_comb begin
    state_d    = state_q;
    issue      = 1'b0;
    issue_wr   = 1'b0;
    issue_addr = ent_addr_q;
    res_ld     = 1'b0;
    fire       = 1'b0;
    ld_fault   = 1'b0;
    ld_large   = 1'b0;
    ld_level   = 1'b0;
    ld_type    = FT_NONE;
    ld_pa      = '0;
    ld_perm    = '0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        issue      = 1'b1;
        issue_addr = dir_ent_addr(dir_base, req_va);
        state_d    = S_DIR;
      end
      S_DIR: if (mem_rsp_valid) begin
        if (chk_flt) begin
          res_ld = 1'b1; fire = 1'b1; ld_fault = 1'b1;
          ld_type = chk_type; ld_level = 1'b0;
          state_d = S_IDLE;
        end else if (chk_leaf) begin
          res_ld   = 1'b1;
          ld_large = 1'b1;
          ld_pa    = large_pa(mem_rsp_rdata, va_q);
          ld_perm  = {mem_rsp_rdata[B_U], mem_rsp_rdata[B_W]};
          if (chk_wb) begin
            issue = 1'b1; issue_wr = 1'b1; state_d = S_WB;
          end else begin
            fire = 1'b1; state_d = S_IDLE;
          end
        end else begin
          issue      = 1'b1;
          issue_addr = tbl_ent_addr(mem_rsp_rdata, va_q);
          state_d    = S_TBL;
        end
      end
      S_TBL: if (mem_rsp_valid) begin
        res_ld = 1'b1;
        if (chk_flt) begin
          fire = 1'b1; ld_fault = 1'b1;
          ld_type = chk_type; ld_level = 1'b1;
          state_d = S_IDLE;
        end else begin
          ld_pa   = small_pa(mem_rsp_rdata, va_q);
          ld_perm = dperm_q & {mem_rsp_rdata[B_U], mem_rsp_rdata[B_W]};
          if (chk_wb) begin
            issue = 1'b1; issue_wr = 1'b1; state_d = S_WB;
          end else begin
            fire = 1'b1; state_d = S_IDLE;
          end
        end
      end
      S_WB: if (mem_done) begin
        fire    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      dperm_q     <= '0;
      ent_addr_q  <= '0;
      wb_old_q    <= '0;
      rsp_valid_q <= 1'b0;
      fault_q     <= 1'b0;
      large_q     <= 1'b0;
      level_q     <= 1'b0;
      ftype_q     <= FT_NONE;
      pa_q        <= '0;
      perm_q      <= '0;
      fva_q       <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= fire;
      if (accept) begin
        va_q  <= req_va;
        wr_q  <= req_write;
        usr_q <= req_user;
      end
      if (issue && !issue_wr) ent_addr_q <= issue_addr;
      if (issue && issue_wr)  wb_old_q   <= mem_rsp_rdata;
      if (state_q == S_DIR && mem_rsp_valid)
        dperm_q <= {mem_rsp_rdata[B_U], mem_rsp_rdata[B_W]};
      if (res_ld) begin
        fault_q <= ld_fault;
        large_q <= ld_large;
        level_q <= ld_level;
        ftype_q <= ld_type;
        pa_q    <= ld_pa;
        perm_q  <= ld_perm;
        fva_q   <= ld_fault ? va_q : '0;
      end
    end
  end

  assign busy          = (state_q != S_IDLE);
  assign rsp_valid     = rsp_valid_q;
  assign rsp_fault     = fault_q;
  assign rsp_pa        = pa_q;
  assign rsp_perm      = perm_q;
  assign rsp_large     = large_q;
  assign rsp_flt_level = level_q;
  assign rsp_flt_type  = ftype_q;
  assign rsp_flt_va    = fva_q;

  // R10: the result strobe lasts one cycle and coincides with the walker going idle
  a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r10_idle_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
  // R10: a request offered during a walk does not disturb the captured address
  a_r10_va_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(va_q));
  // R11: a stalled request keeps its contents
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
  // R8/R9: a write-back only ever adds accessed/dirty to the entry it read
  a_r9_wb_adds_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |->
      ((mem_req_wdata != wb_old_q) && (((mem_req_wdata ^ wb_old_q) & ~AD_MASK) == '0)));
  // R3: a 4 KB translation keeps the byte offset
  a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && !rsp_large) |-> (rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]));
  // R4: a 4 MB translation keeps the low 22 address bits
  a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && rsp_large) |-> (rsp_pa[LOFF_W-1:0] == va_q[LOFF_W-1:0]));
  // R5: a fault always names a type and the request address
  a_r5_fault_rec: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> ((rsp_flt_type != 2'd0) && (rsp_flt_va == va_q)));
endmodule

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] dir_base;
  logic        req_valid, req_write, req_user;
  logic [31:0] req_va;
  logic        busy, rsp_valid, rsp_fault, rsp_large, rsp_flt_level;
  logic [31:0] rsp_pa, rsp_flt_va;
  logic [1:0]  rsp_perm, rsp_flt_type;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  always #2 clk = ~clk;

  pgwalk_top u_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_user(req_user),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_perm(rsp_perm), .rsp_large(rsp_large), .rsp_flt_level(rsp_flt_level),
    .rsp_flt_type(rsp_flt_type), .rsp_flt_va(rsp_flt_va),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [11:0] FP = 12'h001, FW = 12'h002, FU = 12'h004,
                          FA = 12'h020, FD = 12'h040, FL = 12'h080;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int lat_cfg = 1;
  bit stall_mode = 0;
  int n_rd, n_wr;
  logic [31:0] rd_log [4];
  logic [31:0] wr_addr;
  logic [31:0] mem [logic [31:0]];

  int          r_lat;
  bit          r_got;
  logic        r_fault, r_large, r_lvl;
  logic [1:0]  r_perm, r_type;
  logic [31:0] r_pa, r_fva;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] vaddr(input logic [9:0] di, input logic [9:0] ti,
                                        input logic [11:0] off);
    return {di, ti, off};
  endfunction
  function automatic logic [31:0] ent(input logic [19:0] frame, input logic [11:0] fl);
    return {frame, fl};
  endfunction
  function automatic logic [31:0] daddr(input logic [9:0] di);
    return BASE + 32'(di) * 4;
  endfunction
  function automatic logic [31:0] taddr(input logic [19:0] frame, input logic [9:0] ti);
    return {frame, 12'h000} + 32'(ti) * 4;
  endfunction
  function automatic logic [31:0] rdm(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench memory: optional ready stall, fixed read latency per test.
  initial begin
    bit          pend;
    int          cnt;
    logic [31:0] pdata;
    pend = 0; cnt = 0; pdata = '0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        cnt--;
        if (cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_rdata = pdata; pend = 0; end
      end
      mem_req_ready = stall_mode ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
          wr_addr = mem_req_addr;
          n_wr++;
        end else begin
          if (n_rd < 4) rd_log[n_rd] = mem_req_addr;
          n_rd++;
          pend = 1; cnt = lat_cfg; pdata = rdm(mem_req_addr);
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input bit wr, input bit usr, input bit noise);
    int acc;
    n_rd = 0; n_wr = 0; r_got = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
    @(negedge clk);
    acc = cyc;
    if (noise) begin
      req_va = ~va; req_write = ~wr;
      check("R10 busy after accept", 32'(busy), 32'd1);
    end else req_valid = 1'b0;
    for (int i = 0; i < 400 && !r_got; i++) begin
      if (rsp_valid) begin
        r_got = 1; r_lat = cyc - acc;
        r_fault = rsp_fault; r_large = rsp_large; r_lvl = rsp_flt_level;
        r_perm = rsp_perm; r_type = rsp_flt_type; r_pa = rsp_pa; r_fva = rsp_flt_va;
        req_valid = 1'b0;
        check("R10 busy low at result", 32'(busy), 32'd0);
      end else @(negedge clk);
    end
    if (!r_got) check("R10 walk completes", 32'd0, 32'd1);
  endtask

  task automatic t_reset;
    check("R10 reset busy", 32'(busy), 32'd0);
    check("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R10 reset mem_req_valid", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_small_read;
    logic [31:0] pa_t = taddr(20'h00200, 10'h045);
    lat_cfg = 1;
    mem[daddr(10'd3)] = ent(20'h00200, FP | FW);
    mem[pa_t]         = ent(20'hABCDE, FP | FW | FU);
    walk(vaddr(10'd3, 10'h045, 12'h123), 0, 0, 0);
    check("R1 dir entry addr", rd_log[0], daddr(10'd3));
    check("R2 tbl entry addr", rd_log[1], pa_t);
    check("R3 pa", r_pa, 32'hABCDE123);
    check("R3 perm", 32'(r_perm), 32'd1);
    check("R3 not large", 32'(r_large), 32'd0);
    check("R8 one write", 32'(n_wr), 32'd1);
    check("R8 write addr", wr_addr, pa_t);
    check("R8 accessed set", mem[pa_t], ent(20'hABCDE, FP | FW | FU | FA));
    check("R12 latency 4k+wb L1", 32'(r_lat), 32'd5);
  endtask

  task automatic t_small_write;
    logic [31:0] pa_t = taddr(20'h00300, 10'd7);
    lat_cfg = 2;
    mem[daddr(10'd5)] = ent(20'h00300, FP | FW | FU);
    mem[pa_t]         = ent(20'h12345, FP | FW | FU);
    walk(vaddr(10'd5, 10'd7, 12'hFFF), 1, 1, 0);
    check("R3 pa user write", r_pa, 32'h12345FFF);
    check("R3 perm user write", 32'(r_perm), 32'd3);
    check("R8 accessed+dirty", mem[pa_t], ent(20'h12345, FP | FW | FU | FA | FD));
    check("R12 latency 4k+wb L2", 32'(r_lat), 32'd7);
  endtask

  task automatic t_no_redundant;
    lat_cfg = 1;
    walk(vaddr(10'd5, 10'd7, 12'h010), 1, 1, 0);
    check("R9 no write when A/D set", 32'(n_wr), 32'd0);
    check("R9 pa", r_pa, 32'h12345010);
    check("R12 latency no wb L1", 32'(r_lat), 32'd4);
    walk(vaddr(10'd3, 10'h045, 12'h000), 0, 0, 0);
    check("R9 read with A set no write", 32'(n_wr), 32'd0);
  endtask

  task automatic t_large;
    logic [31:0] va = vaddr(10'h200, 10'h155, 12'h0AB);
    lat_cfg = 3;
    mem[daddr(10'h200)] = 32'hFFC0_0000 | 32'(FP | FW | FU | FL);
    walk(va, 0, 1, 0);
    check("R4 pa", r_pa, {10'h3FF, va[21:0]});
    check("R4 large flag", 32'(r_large), 32'd1);
    check("R4 perm", 32'(r_perm), 32'd3);
    check("R4 single read", 32'(n_rd), 32'd1);
    check("R8 large accessed", mem[daddr(10'h200)], 32'hFFC0_0000 | 32'(FP | FW | FU | FL | FA));
    check("R12 latency large+wb L3", 32'(r_lat), 32'd5);
  endtask

  task automatic t_not_present;
    logic [31:0] va1 = vaddr(10'd9, 10'd1, 12'h444);
    logic [31:0] va2 = vaddr(10'd3, 10'h046, 12'h004);
    lat_cfg = 2;
    walk(va1, 0, 0, 0);
    check("R5 dir fault", 32'(r_fault), 32'd1);
    check("R5 dir type", 32'(r_type), 32'd1);
    check("R5 dir level", 32'(r_lvl), 32'd0);
    check("R5 dir va", r_fva, va1);
    check("R9 no write on fault", 32'(n_wr), 32'd0);
    check("R12 latency dir fault L2", 32'(r_lat), 32'd3);
    walk(va2, 1, 0, 0);
    check("R5 tbl type", 32'(r_type), 32'd1);
    check("R5 tbl level", 32'(r_lvl), 32'd1);
    check("R5 tbl va", r_fva, va2);
    check("R12 latency tbl fault L2", 32'(r_lat), 32'd6);
  endtask

  task automatic t_user;
    lat_cfg = 1;
    walk(vaddr(10'd3, 10'h045, 12'h000), 0, 1, 0);
    check("R6 dir user fault type", 32'(r_type), 32'd3);
    check("R6 dir user fault level", 32'(r_lvl), 32'd0);
    mem[taddr(20'h00300, 10'd8)] = ent(20'h0AAAA, FP | FW | FA | FD);
    walk(vaddr(10'd5, 10'd8, 12'h000), 0, 1, 0);
    check("R6 tbl user fault type", 32'(r_type), 32'd3);
    check("R6 tbl user fault level", 32'(r_lvl), 32'd1);
    walk(vaddr(10'd5, 10'd8, 12'h00C), 0, 0, 0);
    check("R6 kernel ignores user bit", 32'(r_fault), 32'd0);
    check("R6 kernel pa", r_pa, 32'h0AAAA00C);
  endtask

  task automatic t_write_prot;
    lat_cfg = 1;
    mem[taddr(20'h00300, 10'd9)]  = ent(20'h0BBBB, FP | FU);
    mem[taddr(20'h00300, 10'd10)] = ent(20'h0CCCC, FP);
    walk(vaddr(10'd5, 10'd9, 12'h000), 1, 1, 0);
    check("R7 write fault type", 32'(r_type), 32'd2);
    check("R7 write fault level", 32'(r_lvl), 32'd1);
    check("R7 no write-back", 32'(n_wr), 32'd0);
    walk(vaddr(10'd5, 10'd9, 12'h000), 1, 0, 0);
    check("R7 kernel write fault", 32'(r_type), 32'd2);
    walk(vaddr(10'd5, 10'd10, 12'h000), 1, 1, 0);
    check("R7 user before write priority", 32'(r_type), 32'd3);
  endtask

  task automatic t_busy_ignore;
    lat_cfg = 4;
    mem[taddr(20'h00300, 10'h020)] = ent(20'h0BEEF, FP | FW | FA | FD);
    walk(vaddr(10'd5, 10'h020, 12'h010), 0, 0, 1);
    check("R10 result of first request", r_pa, 32'h0BEEF010);
    check("R10 only two reads", 32'(n_rd), 32'd2);
    check("R12 latency no wb L4", 32'(r_lat), 32'd10);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rsp_valid || mem_req_valid || busy) check("R10 quiet after result", 32'd1, 32'd0);
    end
  endtask

  task automatic t_stall;
    logic [31:0] pa_t = taddr(20'h00300, 10'h021);
    lat_cfg = 2; stall_mode = 1;
    mem[pa_t] = ent(20'h0CAFE, FP | FW);
    walk(vaddr(10'd5, 10'h021, 12'h3C4), 1, 0, 0);
    stall_mode = 0;
    check("R11 pa under stall", r_pa, 32'h0CAFE3C4);
    check("R11 tbl addr under stall", rd_log[1], pa_t);
    check("R11 write-back under stall", mem[pa_t], ent(20'h0CAFE, FP | FW | FA | FD));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dir_base = BASE;
    req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_user = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_small_read();
    t_small_write();
    t_no_redundant();
    t_large();
    t_not_present();
    t_user();
    t_write_prot();
    t_busy_ignore();
    t_stall();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule